// File: doc/BRIEF.md
# Local Register Window with Configuration Hold-Off

This block sits between a local processor bus and a small internal register file. Every local bus access whose upper sixteen address bits equal a programmable window base is claimed as an internal register access. The window spans 64 KB, but only its lowest 256 bytes are decoded. A word-aligned offset selects one of these registers:

| Offset | Register |
|---|---|
| 0x00 | Window base, bits 15:0 |
| 0x04 | Control, bit 0 = configuration hold |
| 0x08 | Read-only identity word |
| 0x0C | Seal, bit 0 |
| 0x40 and up | Block of scratch words |

Every other offset in the window is claimed but reserved.

The block also keeps host configuration requests waiting until the local processor has finished initialisation. The hold bit is forced to 1 while reset is asserted. While it is 1, every configuration request is answered with a retry. Local software clears the hold bit and then, in its next write, sets the seal bit. Once sealed, the hold bit and the window base are frozen until the next reset.

A four-state machine tracks the hold and seal bits:

- States: `ST_HOLD` (hold on, unsealed; the reset state), `ST_OPEN` (hold off, unsealed), `ST_SEAL_HOLD` (hold on, sealed) and `ST_SEAL_OPEN` (hold off, sealed).
- Transitions:
  - clear: `ST_HOLD` to `ST_OPEN`.
  - rearm: `ST_OPEN` to `ST_HOLD`.
  - seal-while-held: `ST_HOLD` to `ST_SEAL_HOLD`.
  - seal-while-open: `ST_OPEN` to `ST_SEAL_OPEN`.
- Both sealed states are absorbing until reset.

Top module: `lrw_aperture_gate`

## Requirements
- R1: An access presented with `lb_valid` high is claimed when `lb_addr[31:16]` equals the window base. `lb_claim` is high for exactly the following cycle. An unmatched or absent access leaves `lb_claim` low.
- R2: The window base resets to 0x0000. It is written at offset 0x00, with lanes 0 and 1 carrying bits 15:0. A new base applies from the next access, and the old base then no longer claims.
- R3: A claimed read returns the addressed register in `lb_rdata` on the cycle after the access. With the base at 0x1234, a read of 0x12340008 returns the identity word `ID_VALUE`.
- R4: Reserved offsets are claimed; this covers offsets 0x10 to 0x3F and 0x80 to 0xFF inside the low 256 bytes, and 0x100 to 0xFFFF. Reads from them return zero. Writes to them change no register, including the scratch word whose low offset bits they share.
- R5: Writes are little-endian. `lb_be[i]` enables `lb_wdata[8i+7:8i]`, which is stored at byte offset i of the addressed word. Lanes that are not enabled keep their old contents.
- R6: The hold bit is bit 0 of offset 0x04. It is 1 during reset and 1 after reset.
- R7: A configuration request (`cfg_req`) is answered on the next cycle. The answer is `cfg_retry` if the hold bit was 1 in the request cycle, and `cfg_ack` otherwise. The two answers are never high together.
- R8: A configuration request in the same cycle as the local write that clears the hold bit still gets `cfg_retry`. The next request gets `cfg_ack`.
- R9: The seal is set by writing 1 to bit 0 of offset 0x0C. Once it is set, writes to the hold bit and to the window base are ignored, writing 0 to the seal has no effect, and the seal reads back as 1. Only reset clears it.
- R10: `lb_rdata` is zero on the cycle after any write, any unclaimed access, or no access. After reset, `lb_claim`, `lb_rdata`, `cfg_retry` and `cfg_ack` are all zero.
- R11: While unsealed, the hold bit can be written back to 1. Configuration requests are then retried again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_valid | input | 1 | Local bus access strobe, one cycle per access |
| lb_write | input | 1 | 1 = write, 0 = read |
| lb_addr | input | 32 | Local bus byte address |
| lb_be | input | 4 | Byte lane enables, lane 0 = lowest address |
| lb_wdata | input | 32 | Write data |
| lb_claim | output | 1 | Access in previous cycle hit the window |
| lb_rdata | output | 32 | Read data of the previous claimed read, else zero |
| cfg_req | input | 1 | Host configuration request, one cycle |
| cfg_retry | output | 1 | Previous request is told to retry |
| cfg_ack | output | 1 | Previous request completes |

## Verification
The local write that clears the hold bit and a host configuration request can land in the same clock cycle. The bench drives both on one falling edge. It then expects a retry for that request and a completion for the request that follows, which shows that the answer follows the hold bit as it stood before the write. A second collision is also covered: a write to the window base in the same access sequence as the seal. Here the bench checks that the base and the hold bit stop moving once the seal reads back as 1.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

    typedef enum logic [1:0] {
        ST_HOLD      = 2'd0,
        ST_OPEN      = 2'd1,
        ST_SEAL_HOLD = 2'd2,
        ST_SEAL_OPEN = 2'd3
    } gate_state_t;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_BASE = 3'd1,
        TGT_CTRL = 3'd2,
        TGT_ID   = 3'd3,
        TGT_SYS  = 3'd4,
        TGT_SCR  = 3'd5,
        TGT_RSVD = 3'd6
    } target_t;

    // word indexes inside the decoded 256-byte space
    localparam int unsigned WIDX_BASE = 0;
    localparam int unsigned WIDX_CTRL = 1;
    localparam int unsigned WIDX_ID   = 2;
    localparam int unsigned WIDX_SYS  = 3;
    localparam int unsigned WIDX_SCR0 = 16;
    localparam int unsigned DECODED_BYTES = 256;

endpackage

// File: rtl/lrw_decode.sv
module lrw_decode
    import lrw_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BASE_W    = 16,
    parameter int unsigned SCR_WORDS = 16,
    parameter int unsigned SCR_IW    = 4
) (
    input  logic                lb_valid,
    input  logic [ADDR_W-1:0]   lb_addr,
    input  logic [BASE_W-1:0]   base_q,
    output logic                hit,
    output target_t             tgt,
    output logic [SCR_IW-1:0]   scr_idx
);

    localparam int unsigned OFF_W  = ADDR_W - BASE_W;
    localparam int unsigned LOW_W  = $clog2(DECODED_BYTES);
    localparam int unsigned WORD_W = LOW_W - 2;

    logic [OFF_W-1:0]  offset;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] scr_off;
    logic              in_low;

    assign offset  = lb_addr[OFF_W-1:0];
    assign word    = offset[LOW_W-1:2];
    assign in_low  = (offset[OFF_W-1:LOW_W] == '0);
    assign hit     = lb_valid && (lb_addr[ADDR_W-1:OFF_W] == base_q);
    assign scr_off = word - WORD_W'(WIDX_SCR0);
    assign scr_idx = scr_off[SCR_IW-1:0];

    always_comb begin
        tgt = TGT_NONE;
        if (hit) begin
            tgt = TGT_RSVD;
            if (in_low) begin
                if (word == WORD_W'(WIDX_BASE))      tgt = TGT_BASE;
                else if (word == WORD_W'(WIDX_CTRL)) tgt = TGT_CTRL;
                else if (word == WORD_W'(WIDX_ID))   tgt = TGT_ID;
                else if (word == WORD_W'(WIDX_SYS))  tgt = TGT_SYS;
                else if (32'(word) >= WIDX_SCR0 && 32'(word) < WIDX_SCR0 + SCR_WORDS)
                    tgt = TGT_SCR;
            end
        end
    end

endmodule

// File: rtl/lrw_gate_fsm.sv
module lrw_gate_fsm
    import lrw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_val,
    input  logic seal_wr,
    input  logic cfg_req,
    output logic retry_en,
    output logic sealed,
    output logic cfg_retry,
    output logic cfg_ack
);

    gate_state_t state_q;
    gate_state_t state_d;

    // state register; reset holds the configuration gate closed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (seal_wr)                  state_d = ST_SEAL_HOLD;
                else if (ctrl_wr && !ctrl_val) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (seal_wr)                  state_d = ST_SEAL_OPEN;
                else if (ctrl_wr && ctrl_val) state_d = ST_HOLD;
            end
            ST_SEAL_HOLD: state_d = ST_SEAL_HOLD;
            ST_SEAL_OPEN: state_d = ST_SEAL_OPEN;
            default:      state_d = ST_HOLD;
        endcase
    end

    assign retry_en = (state_q == ST_HOLD) || (state_q == ST_SEAL_HOLD);
    assign sealed   = (state_q == ST_SEAL_HOLD) || (state_q == ST_SEAL_OPEN);

    // output process: answer judged on the hold bit before this edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_retry <= 1'b0;
            cfg_ack   <= 1'b0;
        end else begin
            cfg_retry <= cfg_req && retry_en;
            cfg_ack   <= cfg_req && !retry_en;
        end
    end

endmodule

// File: rtl/lrw_regs.sv
module lrw_regs
    import lrw_pkg::*;
#(
    parameter int unsigned     DATA_W    = 32,
    parameter int unsigned     BASE_W    = 16,
    parameter int unsigned     SCR_WORDS = 16,
    parameter int unsigned     SCR_IW    = 4,
    parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  target_t             tgt,
    input  logic [SCR_IW-1:0]   scr_idx,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                retry_en,
    input  logic                sealed,
    output logic [BASE_W-1:0]   base_q,
    output logic [DATA_W-1:0]   rdata
);

    localparam int unsigned NLANE      = DATA_W / 8;
    localparam int unsigned BASE_LANES = BASE_W / 8;

    logic [DATA_W-1:0] scr_q [SCR_WORDS];
    logic [DATA_W-1:0] rd_mux;

    // window base: lockable, per-lane writes
    for (genvar l = 0; l < BASE_LANES; l++) begin : g_base_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                base_q[8*l +: 8] <= 8'h00;
            else if (wr_en && tgt == TGT_BASE && be[l] && !sealed)
                base_q[8*l +: 8] <= wdata[8*l +: 8];
        end
    end

    // scratch words: unlocked, per-lane writes
    for (genvar w = 0; w < SCR_WORDS; w++) begin : g_scr_word
        for (genvar l = 0; l < NLANE; l++) begin : g_scr_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    scr_q[w][8*l +: 8] <= 8'h00;
                else if (wr_en && tgt == TGT_SCR && scr_idx == SCR_IW'(w) && be[l])
                    scr_q[w][8*l +: 8] <= wdata[8*l +: 8];
            end
        end
    end

    always_comb begin
        case (tgt)
            TGT_BASE: rd_mux = DATA_W'(base_q);
            TGT_CTRL: rd_mux = DATA_W'(retry_en);
            TGT_ID:   rd_mux = ID_VALUE;
            TGT_SYS:  rd_mux = DATA_W'(sealed);
            TGT_SCR:  rd_mux = scr_q[scr_idx];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end

endmodule

// File: rtl/lrw_aperture_gate.sv
module lrw_aperture_gate
    import lrw_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       BASE_W    = 16,
    parameter int unsigned       SCR_WORDS = 16,
    parameter logic [DATA_W-1:0] ID_VALUE  = 32'h4C52_0107
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lb_valid,
    input  logic                lb_write,
    input  logic [ADDR_W-1:0]   lb_addr,
    input  logic [DATA_W/8-1:0] lb_be,
    input  logic [DATA_W-1:0]   lb_wdata,
    output logic                lb_claim,
    output logic [DATA_W-1:0]   lb_rdata,
    input  logic                cfg_req,
    output logic                cfg_retry,
    output logic                cfg_ack
);

    localparam int unsigned SCR_IW = (SCR_WORDS > 1) ? $clog2(SCR_WORDS) : 1;

    logic [BASE_W-1:0] base_q;
    logic              hit;
    target_t           tgt;
    logic [SCR_IW-1:0] scr_idx;
    logic              retry_en;
    logic              sealed;
    logic              ctrl_wr;
    logic              seal_wr;
    logic              claim_q;

    lrw_decode #(
        .ADDR_W(ADDR_W), .BASE_W(BASE_W),
        .SCR_WORDS(SCR_WORDS), .SCR_IW(SCR_IW)
    ) u_dec (
        .lb_valid(lb_valid), .lb_addr(lb_addr), .base_q(base_q),
        .hit(hit), .tgt(tgt), .scr_idx(scr_idx)
    );

    assign ctrl_wr = hit && lb_write && (tgt == TGT_CTRL) && lb_be[0];
    assign seal_wr = hit && lb_write && (tgt == TGT_SYS) && lb_be[0] && lb_wdata[0];

    lrw_gate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_val(lb_wdata[0]), .seal_wr(seal_wr),
        .cfg_req(cfg_req),
        .retry_en(retry_en), .sealed(sealed),
        .cfg_retry(cfg_retry), .cfg_ack(cfg_ack)
    );

    lrw_regs #(
        .DATA_W(DATA_W), .BASE_W(BASE_W), .SCR_WORDS(SCR_WORDS),
        .SCR_IW(SCR_IW), .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(hit && lb_write), .rd_en(hit && !lb_write),
        .tgt(tgt), .scr_idx(scr_idx), .be(lb_be), .wdata(lb_wdata),
        .retry_en(retry_en), .sealed(sealed),
        .base_q(base_q), .rdata(lb_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) claim_q <= 1'b0;
        else        claim_q <= hit;
    end

    assign lb_claim = claim_q;

endmodule

// File: rtl/lrw_checker.sv
module lrw_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BASE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lb_valid,
    input logic              lb_write,
    input logic [ADDR_W-1:0] lb_addr,
    input logic [BASE_W-1:0] base_q,
    input logic              lb_claim,
    input logic [DATA_W-1:0] lb_rdata,
    input logic              cfg_req,
    input logic              cfg_retry,
    input logic              cfg_ack,
    input logic              retry_en,
    input logic              sealed
);

    AST_CLAIM_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_valid && lb_addr[ADDR_W-1:ADDR_W-BASE_W] == base_q) |=> lb_claim); // R1
    AST_NO_CLAIM_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lb_valid || lb_addr[ADDR_W-1:ADDR_W-BASE_W] != base_q) |=> !lb_claim); // R1
    AST_RETRY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && retry_en) |=> (cfg_retry && !cfg_ack)); // R7
    AST_ACK_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !retry_en) |=> (cfg_ack && !cfg_retry)); // R7
    AST_ANSWERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_retry && cfg_ack)); // R7
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req |=> (!cfg_retry && !cfg_ack)); // R7
    AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed); // R9
    AST_SEAL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> ($stable(base_q) && $stable(retry_en))); // R9
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!lb_valid || lb_write) |=> (lb_rdata == '0)); // R10

endmodule

bind lrw_aperture_gate lrw_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_W(BASE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lb_valid(lb_valid), .lb_write(lb_write),
    .lb_addr(lb_addr), .base_q(base_q), .lb_claim(lb_claim), .lb_rdata(lb_rdata),
    .cfg_req(cfg_req), .cfg_retry(cfg_retry), .cfg_ack(cfg_ack),
    .retry_en(retry_en), .sealed(sealed)
);

// File: tb/lrw_aperture_gate_test.sv
module lrw_aperture_gate_test;

    localparam logic [31:0] ID = 32'h4C52_0107;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        claim;
        logic [31:0] rdata;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h0000_0008, 4'hF, 32'h0,         1'b1, ID,            8'd3},  // R3 id at base 0
        '{1'b0, 32'h0000_0000, 4'hF, 32'h0,         1'b1, 32'h0,         8'd2},  // R2 base reset value
        '{1'b0, 32'h0000_0004, 4'hF, 32'h0,         1'b1, 32'h1,         8'd6},  // R6 hold bit after reset
        '{1'b0, 32'h0001_0000, 4'hF, 32'h0,         1'b0, 32'h0,         8'd1},  // R1 miss
        '{1'b1, 32'h0000_0040, 4'hF, 32'hA1B2_C3D4, 1'b1, 32'h0,         8'd10}, // R10 write returns zero
        '{1'b0, 32'h0000_0040, 4'hF, 32'h0,         1'b1, 32'hA1B2_C3D4, 8'd5},  // R5 full word
        '{1'b1, 32'h0000_0040, 4'h5, 32'h1122_3344, 1'b1, 32'h0,         8'd5},  // R5 lanes 0 and 2
        '{1'b0, 32'h0000_0040, 4'hF, 32'h0,         1'b1, 32'hA122_C344, 8'd5},  // R5 merged
        '{1'b1, 32'h0000_0140, 4'hF, 32'hFFFF_FFFF, 1'b1, 32'h0,         8'd4},  // R4 reserved write
        '{1'b0, 32'h0000_0040, 4'hF, 32'h0,         1'b1, 32'hA122_C344, 8'd4},  // R4 alias untouched
        '{1'b0, 32'h0000_0140, 4'hF, 32'h0,         1'b1, 32'h0,         8'd4},  // R4 reserved read
        '{1'b0, 32'h0000_00F0, 4'hF, 32'h0,         1'b1, 32'h0,         8'd4},  // R4 low reserved read
        '{1'b1, 32'h0000_0000, 4'h3, 32'h0000_1234, 1'b1, 32'h0,         8'd2},  // R2 move base
        '{1'b0, 32'h0000_0008, 4'hF, 32'h0,         1'b0, 32'h0,         8'd2},  // R2 old base dead
        '{1'b0, 32'h1234_0008, 4'hF, 32'h0,         1'b1, ID,            8'd3},  // R3 id at new base
        '{1'b0, 32'h1234_0000, 4'hF, 32'h0,         1'b1, 32'h0000_1234, 8'd2},  // R2 base readback
        '{1'b1, 32'h1234_0044, 4'h8, 32'hEE00_0000, 1'b1, 32'h0,         8'd5},  // R5 lane 3 only
        '{1'b0, 32'h1234_0044, 4'hF, 32'h0,         1'b1, 32'hEE00_0000, 8'd5}   // R5 lane 3 readback
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lb_valid = 1'b0;
    logic        lb_write = 1'b0;
    logic [31:0] lb_addr = '0;
    logic [3:0]  lb_be = '0;
    logic [31:0] lb_wdata = '0;
    logic        lb_claim;
    logic [31:0] lb_rdata;
    logic        cfg_req = 1'b0;
    logic        cfg_retry;
    logic        cfg_ack;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lrw_aperture_gate uut (
        .clk(clk), .rst_n(rst_n),
        .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr),
        .lb_be(lb_be), .lb_wdata(lb_wdata),
        .lb_claim(lb_claim), .lb_rdata(lb_rdata),
        .cfg_req(cfg_req), .cfg_retry(cfg_retry), .cfg_ack(cfg_ack)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access; outputs sampled on the falling edge after the capturing edge
    task automatic access(logic wr, logic [31:0] a, logic [3:0] be, logic [31:0] d,
                          output logic cl, output logic [31:0] rd);
        @(negedge clk);
        lb_valid = 1'b1; lb_write = wr; lb_addr = a; lb_be = be; lb_wdata = d;
        @(negedge clk);
        lb_valid = 1'b0; lb_write = 1'b0;
        cl = lb_claim; rd = lb_rdata;
    endtask

    task automatic cfg(output logic rt, output logic ak);
        @(negedge clk);
        cfg_req = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0;
        rt = cfg_retry; ak = cfg_ack;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic cl, rt, ak;
        logic [31:0] rd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state at ports
        check("R10 claim after reset", 32'(lb_claim), 32'h0);
        check("R10 rdata after reset", lb_rdata, 32'h0);
        check("R10 retry after reset", 32'(cfg_retry), 32'h0);
        check("R10 ack after reset", 32'(cfg_ack), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata, cl, rd);
            check($sformatf("R%0d vec%0d claim", VECS[i].req, i), 32'(cl), 32'(VECS[i].claim));
            check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rd, VECS[i].rdata);
        end

        // R7 held gate retries
        cfg(rt, ak);
        check("R7 retry while held", {30'b0, rt, ak}, 32'h2);

        // R11 clear, then rearm while unsealed
        access(1'b1, 32'h1234_0004, 4'h1, 32'h0, cl, rd);
        access(1'b0, 32'h1234_0004, 4'hF, 32'h0, cl, rd);
        check("R11 hold cleared", rd, 32'h0);
        cfg(rt, ak);
        check("R7 ack when open", {30'b0, rt, ak}, 32'h1);
        access(1'b1, 32'h1234_0004, 4'h1, 32'h1, cl, rd);
        cfg(rt, ak);
        check("R11 rearmed retries", {30'b0, rt, ak}, 32'h2);

        // R8 clear and request in the same cycle
        @(negedge clk);
        lb_valid = 1'b1; lb_write = 1'b1; lb_addr = 32'h1234_0004; lb_be = 4'h1; lb_wdata = 32'h0;
        cfg_req = 1'b1;
        @(negedge clk);
        lb_valid = 1'b0; lb_write = 1'b0; cfg_req = 1'b0;
        check("R8 collision retried", {30'b0, cfg_retry, cfg_ack}, 32'h2);
        cfg(rt, ak);
        check("R8 following request acked", {30'b0, rt, ak}, 32'h1);

        // R9 seal, then attempt to move hold bit and base
        access(1'b1, 32'h1234_000C, 4'h1, 32'h1, cl, rd);
        access(1'b0, 32'h1234_000C, 4'hF, 32'h0, cl, rd);
        check("R9 seal reads one", rd, 32'h1);
        access(1'b1, 32'h1234_0004, 4'h1, 32'h1, cl, rd);
        access(1'b0, 32'h1234_0004, 4'hF, 32'h0, cl, rd);
        check("R9 hold frozen", rd, 32'h0);
        cfg(rt, ak);
        check("R9 still acked", {30'b0, rt, ak}, 32'h1);
        access(1'b1, 32'h1234_0000, 4'h3, 32'h0000_5555, cl, rd);
        access(1'b0, 32'h1234_0000, 4'hF, 32'h0, cl, rd);
        check("R9 base frozen claim", 32'(cl), 32'h1);
        check("R9 base frozen value", rd, 32'h0000_1234);
        access(1'b1, 32'h1234_000C, 4'h1, 32'h0, cl, rd);
        access(1'b0, 32'h1234_000C, 4'hF, 32'h0, cl, rd);
        check("R9 seal not clearable", rd, 32'h1);

        // R6 and R9: reset reopens everything
        do_reset();
        access(1'b0, 32'h0000_0004, 4'hF, 32'h0, cl, rd);
        check("R6 hold back after reset", rd, 32'h1);
        access(1'b0, 32'h0000_000C, 4'hF, 32'h0, cl, rd);
        check("R9 seal cleared by reset", rd, 32'h0);
        check("R2 base back to zero", 32'(cl), 32'h1);
        cfg(rt, ak);
        check("R7 retry after reset", {30'b0, rt, ak}, 32'h2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule